// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block holds the per-channel control and status registers for a small DMA controller. Each channel has one 8-bit register at an even byte offset: channel 0 at 0, channel 1 at 2, and so on. The CPU reaches the registers through a plain register port with an address, a write strobe, write data, a read strobe and combinational read data. The transfer engine reports terminal-count events, whether the last transfer read from internal RAM, and whether a channel is suspended. It also presents hardware transfer requests.

The block applies the channel rules. These cover when the enable level falls, when the terminal-count flag rises and clears, when a software start is issued, when a hardware request is accepted, and when a forced termination is issued. Its outputs to the engine are the enable level and three single-cycle pulses per channel: start, abort and accept.

Register layout, used by the requirements below:
- bit 0: enable
- bit 1: software start (write-only)
- bit 2: terminate (write-only)
- bit 3: keep-enable
- bit 7: terminal count (read-only)

Top module: `dma_chan_ctl_bank`

## Requirements
- R1: After a synchronous reset every register reads 00h, every `ch_en` bit is 0, and no start, abort or accept pulse is issued.
- R2: Offset 2*n reads {terminal count, 000, keep-enable, 00, enable} of channel n: bit 7, bits 6..4 = 0, bit 3, bits 2..1 = 0, bit 0. A write sets enable to (bit 0 AND NOT bit 2) and keep-enable to bit 3. Odd offsets and offsets at or above 2*NUM_CH read 00h, and writes to them change nothing.
- R3: A terminal-count event with `tc_ram_src` low sets bit 7 at the next clock edge. A read of the channel clears bit 7 at the edge that ends the read cycle. A set and a clearing read in the same cycle leave bit 7 at 1.
- R4: A terminal-count event with `tc_ram_src` high sets bit 7 exactly RAM_DELAY clock edges after the edge that samples the event. The delay is tracked separately for each channel.
- R5: When bit 7 is set with keep-enable 0, enable falls at that same edge, overriding a write in that cycle. With keep-enable 1, enable is unchanged.
- R6: A write with bit 2 = 1 clears enable. If enable was 1 or `ch_suspended` is high, it also issues an abort pulse and cancels any pending delayed terminal-count set for that channel. If the same write also has bit 1 set, no start pulse is issued.
- R7: A write with bit 1 = 1, bit 0 = 1 and bit 2 = 0 issues a start pulse in the next cycle. This happens only if bit 7 is 0 and no terminal-count set occurs in that cycle.
- R8: A `hw_req` bit is accepted with an accept pulse in the next cycle when the channel's enable is 1, whatever bit 7 holds, unless a terminate write to that channel occurs in the same cycle.
- R9: Start, abort and accept are single-cycle pulses. An isolated cause yields exactly one cycle high, and abort and start are never high together on a channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W (4) | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe (clears terminal count of the addressed channel) |
| reg_rdata | output | 8 | Read data of the addressed register, combinational |
| tc_evt | input | NUM_CH (4) | Terminal-count event per channel |
| tc_ram_src | input | NUM_CH (4) | The last transfer read internal RAM (delayed set) |
| ch_suspended | input | NUM_CH (4) | Channel suspended by the engine |
| hw_req | input | NUM_CH (4) | Hardware transfer request |
| ch_en | output | NUM_CH (4) | Enable level per channel |
| ch_start | output | NUM_CH (4) | Software-start pulse |
| ch_abort | output | NUM_CH (4) | Forced-termination pulse |
| ch_accept | output | NUM_CH (4) | Hardware-request accept pulse |

## Verification
The bench builds the block with NUM_CH = 4, RAM_DELAY = 4 and ADDR_W = 4. The wider address makes offsets 8 to 15 reachable, so writes and reads beyond the last channel are exercised as well as odd offsets. With RAM_DELAY = 4, a read or a terminate write can land inside the pending window of a delayed terminal-count set. A second event can also reload a running delay. The channel count is large enough for channels to be written and read while other channels' events and requests are in flight.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    localparam int REG_W     = 8;
    localparam int BIT_EN    = 0;
    localparam int BIT_START = 1;
    localparam int BIT_TERM  = 2;
    localparam int BIT_KEEP  = 3;
    localparam int BIT_TC    = 7;

    typedef struct packed {
        logic tc;
        logic keep;
        logic en;
    } chan_state_t;

    typedef struct packed {
        logic en;
        logic start;
        logic term;
        logic keep;
    } wr_fields_t;

    typedef struct packed {
        logic start;
        logic abort;
        logic accept;
    } chan_pulse_t;

    function automatic wr_fields_t unpack_wr(input logic [REG_W-1:0] d);
        wr_fields_t f;
        f.en    = d[BIT_EN];
        f.start = d[BIT_START];
        f.term  = d[BIT_TERM];
        f.keep  = d[BIT_KEEP];
        return f;
    endfunction

    function automatic logic [REG_W-1:0] pack_rd(input chan_state_t s);
        logic [REG_W-1:0] r;
        r           = '0;
        r[BIT_EN]   = s.en;
        r[BIT_KEEP] = s.keep;
        r[BIT_TC]   = s.tc;
        return r;
    endfunction

endpackage

// File: rtl/dcc_addr_dec.sv
module dcc_addr_dec #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic [NUM_CH-1:0] hit,
    output logic [NUM_CH-1:0] wr_sel,
    output logic [NUM_CH-1:0] rd_sel
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(2 * i);
        assign hit[i]    = (addr == OFFS);
        assign wr_sel[i] = hit[i] & wr;
        assign rd_sel[i] = hit[i] & rd;
    end
endmodule

// File: rtl/dcc_tc_delay.sv
module dcc_tc_delay #(
    parameter int RAM_DELAY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic cancel,
    output logic fire
);
    localparam int CW = $clog2(RAM_DELAY + 1);
    localparam logic [CW-1:0] LOAD_V = CW'(RAM_DELAY);
    localparam logic [CW-1:0] ONE    = CW'(1);

    logic [CW-1:0] cnt;

    assign fire = (cnt == ONE) && !cancel;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cancel) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= LOAD_V;
        end else if (cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end
endmodule

// File: rtl/dcc_channel.sv
module dcc_channel
    import dcc_pkg::*;
#(
    parameter int RAM_DELAY = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_sel,
    input  logic         rd_sel,
    input  wr_fields_t   wf,
    input  logic         tc_evt,
    input  logic         ram_src,
    input  logic         suspended,
    input  logic         hw_req,
    output chan_state_t  st,
    output chan_pulse_t  pls
);
    chan_state_t st_n;
    chan_pulse_t pls_n;
    logic        abort_now;
    logic        term_wr;
    logic        dly_fire;
    logic        tc_set;

    assign term_wr   = wr_sel && wf.term;
    assign abort_now = term_wr && (st.en || suspended);

    dcc_tc_delay #(.RAM_DELAY(RAM_DELAY)) u_dly (
        .clk    (clk),
        .rst    (rst),
        .load   (tc_evt && ram_src),
        .cancel (abort_now),
        .fire   (dly_fire)
    );

    assign tc_set = (tc_evt && !ram_src) || dly_fire;

    always_comb begin
        st_n = st;
        if (wr_sel) begin
            st_n.en   = wf.en && !wf.term;
            st_n.keep = wf.keep;
        end
        if (tc_set && !st.keep) begin
            st_n.en = 1'b0;
        end
        if (tc_set) begin
            st_n.tc = 1'b1;
        end else if (rd_sel) begin
            st_n.tc = 1'b0;
        end
        pls_n.start  = wr_sel && wf.start && wf.en && !wf.term && !st.tc && !tc_set;
        pls_n.abort  = abort_now;
        pls_n.accept = hw_req && st.en && !term_wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '0;
            pls <= '0;
        end else begin
            st  <= st_n;
            pls <= pls_n;
        end
    end
endmodule

// File: rtl/dcc_rd_mux.sv
module dcc_rd_mux
    import dcc_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] hit,
    input  chan_state_t       st [NUM_CH],
    output logic [REG_W-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit[i]) begin
                rdata = rdata | pack_rd(st[i]);
            end
        end
    end
endmodule

// File: rtl/dma_chan_ctl_bank.sv
module dma_chan_ctl_bank
    import dcc_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 4,
    parameter int RAM_DELAY = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_rd,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NUM_CH-1:0] tc_evt,
    input  logic [NUM_CH-1:0] tc_ram_src,
    input  logic [NUM_CH-1:0] ch_suspended,
    input  logic [NUM_CH-1:0] hw_req,
    output logic [NUM_CH-1:0] ch_en,
    output logic [NUM_CH-1:0] ch_start,
    output logic [NUM_CH-1:0] ch_abort,
    output logic [NUM_CH-1:0] ch_accept
);
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] wr_sel;
    logic [NUM_CH-1:0] rd_sel;
    wr_fields_t        wf;
    chan_state_t       st  [NUM_CH];
    chan_pulse_t       pls [NUM_CH];
    logic              unused_wbits;

    assign wf           = unpack_wr(reg_wdata);
    assign unused_wbits = &{1'b0, reg_wdata[REG_W-1:BIT_KEEP+1]};

    dcc_addr_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .addr   (reg_addr),
        .wr     (reg_wr),
        .rd     (reg_rd),
        .hit    (hit),
        .wr_sel (wr_sel),
        .rd_sel (rd_sel)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dcc_channel #(.RAM_DELAY(RAM_DELAY)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .wr_sel    (wr_sel[i]),
            .rd_sel    (rd_sel[i]),
            .wf        (wf),
            .tc_evt    (tc_evt[i]),
            .ram_src   (tc_ram_src[i]),
            .suspended (ch_suspended[i]),
            .hw_req    (hw_req[i]),
            .st        (st[i]),
            .pls       (pls[i])
        );
        assign ch_en[i]     = st[i].en;
        assign ch_start[i]  = pls[i].start;
        assign ch_abort[i]  = pls[i].abort;
        assign ch_accept[i] = pls[i].accept;
    end

    dcc_rd_mux #(.NUM_CH(NUM_CH)) u_mux (
        .hit   (hit),
        .st    (st),
        .rdata (reg_rdata)
    );
endmodule

// File: rtl/dcc_ctl_checker.sv
module dcc_ctl_checker #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        reg_rdata,
    input logic [NUM_CH-1:0] ch_en,
    input logic [NUM_CH-1:0] ch_start,
    input logic [NUM_CH-1:0] ch_abort,
    input logic [NUM_CH-1:0] ch_accept
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (ch_en == '0) && (ch_start == '0) && (ch_abort == '0) && (ch_accept == '0)); // R1

    AST_RD_FIXED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[6:4] == 3'b000) && (reg_rdata[2:1] == 2'b00)); // R2

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ast
        AST_ABORT_DROPS_EN: assert property (@(posedge clk) disable iff (rst)
            ch_abort[i] |-> !ch_en[i]); // R6
        AST_START_WITH_EN: assert property (@(posedge clk) disable iff (rst)
            ch_start[i] |-> ch_en[i]); // R7
        AST_ACCEPT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
            ch_accept[i] |-> $past(ch_en[i])); // R8
        AST_NO_START_ON_ABORT: assert property (@(posedge clk) disable iff (rst)
            !(ch_start[i] && ch_abort[i])); // R9
    end
endmodule

bind dma_chan_ctl_bank dcc_ctl_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_rdata (reg_rdata),
    .ch_en     (ch_en),
    .ch_start  (ch_start),
    .ch_abort  (ch_abort),
    .ch_accept (ch_accept)
);

// File: tb/tb_dma_chan_ctl_bank.sv
module tb_dma_chan_ctl_bank;
    localparam int NCH   = 4;
    localparam int AW    = 4;
    localparam int DLY   = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [AW-1:0]  reg_addr = '0;
    logic           reg_wr = 1'b0;
    logic [7:0]     reg_wdata = '0;
    logic           reg_rd = 1'b0;
    logic [7:0]     reg_rdata;
    logic [NCH-1:0] tc_evt = '0, tc_ram_src = '0, ch_suspended = '0, hw_req = '0;
    logic [NCH-1:0] ch_en, ch_start, ch_abort, ch_accept;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    // reference state
    bit m_en [NCH];
    bit m_keep [NCH];
    bit m_tc [NCH];
    int m_cnt [NCH];

    // observations from the last step
    logic [7:0]     obs_rd;
    logic [NCH-1:0] obs_en, obs_start, obs_abort, obs_acc;

    always #4 clk = ~clk;   // 125 MHz

    dma_chan_ctl_bank #(.NUM_CH(NCH), .ADDR_W(AW), .RAM_DELAY(DLY)) dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rdata(input logic [AW-1:0] a);
        if (a[0] == 1'b0 && int'(a) / 2 < NCH)
            return {m_tc[a/2], 3'b000, m_keep[a/2], 2'b00, m_en[a/2]};
        return 8'h00;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_en[i] = 0; m_keep[i] = 0; m_tc[i] = 0; m_cnt[i] = 0;
        end
    endtask

    // one cycle: inputs already driven at a negedge
    task automatic step();
        logic [7:0] er;
        bit wsel, rsel, term, abort, fire, tset;
        bit n_en [NCH]; bit n_keep [NCH]; bit n_tc [NCH]; int n_cnt [NCH];
        bit e_start [NCH]; bit e_abort [NCH]; bit e_acc [NCH];
        #1;
        obs_rd = reg_rdata;
        er = exp_rdata(reg_addr);
        if (obs_rd[7] != er[7]) chk("R3 tc bit", obs_rd, er);
        else chk("R2 read layout", obs_rd, er);
        for (int i = 0; i < NCH; i++) begin
            wsel  = reg_wr && (reg_addr == AW'(2*i));
            rsel  = reg_rd && (reg_addr == AW'(2*i));
            term  = wsel && reg_wdata[2];
            abort = term && (m_en[i] || ch_suspended[i]);
            fire  = (m_cnt[i] == 1) && !abort;
            tset  = (tc_evt[i] && !tc_ram_src[i]) || fire;
            n_en[i]   = wsel ? (reg_wdata[0] && !reg_wdata[2]) : m_en[i];
            n_keep[i] = wsel ? reg_wdata[3] : m_keep[i];
            if (tset && !m_keep[i]) n_en[i] = 0;
            n_tc[i] = tset ? 1 : (rsel ? 0 : m_tc[i]);
            if (abort) n_cnt[i] = 0;
            else if (tc_evt[i] && tc_ram_src[i]) n_cnt[i] = DLY;
            else if (m_cnt[i] != 0) n_cnt[i] = m_cnt[i] - 1;
            else n_cnt[i] = 0;
            e_start[i] = wsel && reg_wdata[1] && reg_wdata[0] && !reg_wdata[2] && !m_tc[i] && !tset;
            e_abort[i] = abort;
            e_acc[i]   = hw_req[i] && m_en[i] && !term;
        end
        @(posedge clk);
        @(negedge clk);
        obs_en = ch_en; obs_start = ch_start; obs_abort = ch_abort; obs_acc = ch_accept;
        for (int i = 0; i < NCH; i++) begin
            chk("R5 enable level", obs_en[i], n_en[i]);
            chk("R7 start pulse", obs_start[i], e_start[i]);
            chk("R6 abort pulse", obs_abort[i], e_abort[i]);
            chk("R8 accept pulse", obs_acc[i], e_acc[i]);
            m_en[i] = n_en[i]; m_keep[i] = n_keep[i]; m_tc[i] = n_tc[i]; m_cnt[i] = n_cnt[i];
        end
    endtask

    task automatic idle();
        reg_wr = 0; reg_rd = 0; reg_wdata = '0;
        tc_evt = '0; tc_ram_src = '0; ch_suspended = '0; hw_req = '0;
    endtask

    task automatic wr_op(input int a, input logic [7:0] d);
        idle(); reg_addr = AW'(a); reg_wr = 1; reg_wdata = d; step(); idle();
    endtask

    task automatic rd_op(input int a);
        idle(); reg_addr = AW'(a); reg_rd = 1; step(); idle();
    endtask

    task automatic peek(input int a);   // observe without clearing
        idle(); reg_addr = AW'(a); step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset state
        for (int c = 0; c < NCH; c++) begin
            peek(2*c);
            chk("R1 reset rdata", obs_rd, 8'h00);
        end
        chk("R1 reset en", obs_en, 0);
        chk("R1 reset pulses", {obs_start, obs_abort, obs_acc}, 0);

        // R7 start on channel 0, R9 single cycle
        wr_op(0, 8'h0B);
        chk("R7 start issued", obs_start[0], 1);
        peek(0);
        chk("R9 start single cycle", obs_start[0], 0);
        chk("R2 readback en+keep", obs_rd, 8'h09);

        // R6 terminate beats start in the same write
        wr_op(0, 8'h07);
        chk("R6 abort issued", obs_abort[0], 1);
        chk("R6 no start with terminate", obs_start[0], 0);
        chk("R6 enable cleared", obs_en[0], 0);
        peek(0);
        chk("R9 abort single cycle", obs_abort[0], 0);

        // R4 delayed set on channel 1
        idle(); tc_evt[1] = 1; tc_ram_src[1] = 1; reg_addr = 2; step(); idle();
        for (int k = 1; k <= DLY; k++) begin
            peek(2);
            chk("R4 tc still clear in delay", obs_rd[7], 0);
        end
        peek(2);
        chk("R4 tc set after delay", obs_rd[7], 1);
        rd_op(2);
        peek(2);
        chk("R3 read clears tc", obs_rd[7], 0);

        // R3 set and read in the same cycle
        idle(); tc_evt[2] = 1; reg_addr = 4; reg_rd = 1; step(); idle();
        peek(4);
        chk("R3 set beats read", obs_rd[7], 1);

        // R5 keep-enable, R8 accept with tc set, R7 blocked by tc
        wr_op(6, 8'h09);
        idle(); tc_evt[3] = 1; step(); idle();
        chk("R5 enable kept", obs_en[3], 1);
        idle(); hw_req[3] = 1; step(); idle();
        chk("R8 accept with tc set", obs_acc[3], 1);
        wr_op(6, 8'h0B);
        chk("R7 start refused while tc", obs_start[3], 0);
        rd_op(6);
        wr_op(6, 8'h0B);
        chk("R7 start after tc read", obs_start[3], 1);
        // R5 without keep: enable falls
        wr_op(6, 8'h01);
        idle(); tc_evt[3] = 1; step(); idle();
        chk("R5 enable dropped", obs_en[3], 0);

        // R2 odd and out-of-range offsets
        wr_op(1, 8'h09);
        wr_op(9, 8'h09);
        chk("R2 ignored writes", obs_en, 4'b0000);
        peek(1);  chk("R2 odd offset reads zero", obs_rd, 8'h00);
        peek(10); chk("R2 high offset reads zero", obs_rd, 8'h00);

        // R6 terminate cancels a pending delayed set
        wr_op(2, 8'h01);
        idle(); tc_evt[1] = 1; tc_ram_src[1] = 1; step(); idle();
        peek(2);
        wr_op(2, 8'h04);
        chk("R6 abort during delay", obs_abort[1], 1);
        repeat (DLY + 1) peek(2);
        chk("R6 pending set cancelled", obs_rd[7], 0);

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            idle();
            reg_addr  = AW'($urandom % 10);
            reg_wr    = ($urandom % 4) == 0;
            reg_rd    = ($urandom % 3) == 0;
            reg_wdata = 8'($urandom);
            reg_wdata[0] = ($urandom % 10) < 7;
            reg_wdata[2] = ($urandom % 10) == 0;
            for (int c = 0; c < NCH; c++) begin
                tc_evt[c]       = ($urandom % 12) == 0;
                tc_ram_src[c]   = $urandom % 2;
                ch_suspended[c] = ($urandom % 10) == 0;
                hw_req[c]       = ($urandom % 3) == 0;
            end
            step();
        end
        idle();
        finish_run();
    end
endmodule